// File: doc/BRIEF.md
# Execute-Stage Squash Redirect Generator

This block sits at the end of an out-of-order execute stage. Each cycle, any of several execution ports may report that the instruction it just finished must cause a squash. Either a branch resolved against its prediction, or a memory-ordering violation was detected. Each report carries a cause bit, the instruction's sequence number, its PC, its computed target and its predicted-taken bit. The block picks the oldest report and turns it into one registered squash-and-redirect message for the commit stage.

A branch squash carries the full redirect: the mispredicted PC, the next fetch address and the corrected direction. The corrected direction comes from comparing the computed target with the fall-through address; it is not the inverse of the prediction. A memory squash carries only the sequence number and the next fetch address, and leaves the branch flag clear.

The block also keeps a squashing status bit, which commit releases. It counts mispredicted branches that had been predicted taken, and it counts memory-ordering violations.

Top module: `squash_redirect_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is zero after that edge.
- R2: An event accepted at a clock edge drives `sq_valid` high for exactly the following cycle; with no event at the next edge `sq_valid` returns low.
- R3: A winning branch event (`ev_is_mem` bit = 0) gives `sq_branch_mispredict`=1, `sq_seq`=its sequence number, `sq_mispred_pc`=its PC and `sq_next_pc`=its computed target.
- R4: For a branch message, `sq_taken` is 1 exactly when the target differs from PC + `INST_BYTES` (default 4, 32-bit PCs); the predicted-taken bit does not affect it.
- R5: A winning memory event (`ev_is_mem` bit = 1) gives `sq_seq`=its sequence number and `sq_next_pc`=its target, with `sq_branch_mispredict`, `sq_taken` and `sq_mispred_pc` all zero.
- R6: Among valid same-cycle events, the one with the smallest sequence number (unsigned) wins.
- R7: On equal sequence numbers a branch event beats a memory event; between events of equal cause and number the lower port index wins.
- R8: `squashing` goes high after any accepted event and stays high until an edge where `squash_release` is high and no event is presented; an event at the same edge as a release keeps it high.
- R9: `cnt_pred_taken_wrong` increments by one, in the same cycle as the message, for each winning branch event whose predicted-taken bit is 1.
- R10: `cnt_mem_order` increments by one, in the same cycle as the message, for each winning memory event.
- R11: While `sq_valid` is low, `sq_seq`, `sq_mispred_pc`, `sq_next_pc`, `sq_branch_mispredict` and `sq_taken` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | NUM_PORTS | One-cycle squash event strobe per port |
| ev_is_mem | input | NUM_PORTS | Cause per port: 0 branch, 1 memory violation |
| ev_pred_taken | input | NUM_PORTS | Predicted-taken bit per port |
| ev_seq | input | NUM_PORTS*SEQ_W | Sequence numbers, port p at bits p*SEQ_W upward |
| ev_pc | input | NUM_PORTS*PC_W | Instruction PCs, port p at bits p*PC_W upward |
| ev_target | input | NUM_PORTS*PC_W | Computed targets, port p at bits p*PC_W upward |
| squash_release | input | 1 | Commit's indication that squashing may end |
| sq_valid | output | 1 | Message valid, one cycle per accepted event |
| sq_seq | output | SEQ_W | Squashed sequence number |
| sq_mispred_pc | output | PC_W | PC of the mispredicted branch |
| sq_next_pc | output | PC_W | Redirect fetch address |
| sq_branch_mispredict | output | 1 | Message is a branch mispredict |
| sq_taken | output | 1 | Corrected branch direction |
| squashing | output | 1 | Stage squashing status |
| cnt_pred_taken_wrong | output | CNT_W | Count of mispredicted predicted-taken branches |
| cnt_mem_order | output | CNT_W | Count of memory-ordering violations |

## Verification
Every cycle, the assertions check the following:
- the squashing status is high whenever a message is out;
- a memory message leaves the branch-only fields clear;
- idle message fields are zero;
- each counter moves only in a cycle that carries a message of its own kind;
- every message follows an event one cycle earlier.

Which port wins and what the message holds can only be shown by the bench's sweeps. The sweeps cover every mix of validity, cause, age order, prediction and target direction on two ports. They check the winner, the taken derivation from the target and the running counter totals, and the release handshake of the squashing status.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
    // Cause encoding on ev_is_mem
    typedef enum logic {
        CAUSE_BRANCH = 1'b0,
        CAUSE_MEMORY = 1'b1
    } sqr_cause_e;
endpackage

// File: rtl/sqr_age_arbiter.sv
// Age arbiter: selects the valid request with the smallest sequence number.
// Ties go to a branch over a memory event, then to the lower port index.
// Assumes sequence numbers do not wrap within the window in flight.
module sqr_age_arbiter #(
    parameter int NUM_PORTS = 2,
    parameter int SEQ_W     = 16,
    parameter int IDX_W     = 1
) (
    input  logic [NUM_PORTS-1:0]       req,
    input  logic [NUM_PORTS-1:0]       is_mem,
    input  logic [NUM_PORTS*SEQ_W-1:0] seq,
    output logic                       any,
    output logic [IDX_W-1:0]           idx
);
    import sqr_pkg::*;

    logic             ch_any [0:NUM_PORTS];
    logic [IDX_W-1:0] ch_idx [0:NUM_PORTS];
    logic [SEQ_W-1:0] ch_seq [0:NUM_PORTS];
    logic             ch_mem [0:NUM_PORTS];

    assign ch_any[0] = 1'b0;
    assign ch_idx[0] = '0;
    assign ch_seq[0] = '0;
    assign ch_mem[0] = 1'b0;

    // One compare stage per port along a linear chain
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_stage
        logic [SEQ_W-1:0] s;
        logic             older;
        logic             tie_win;
        logic             take;
        assign s       = seq[i*SEQ_W +: SEQ_W];
        assign older   = s < ch_seq[i];
        assign tie_win = (s == ch_seq[i]) && (is_mem[i] == CAUSE_BRANCH) && ch_mem[i];
        assign take    = req[i] && (!ch_any[i] || older || tie_win);
        assign ch_any[i+1] = ch_any[i] | req[i];
        assign ch_idx[i+1] = take ? IDX_W'(i) : ch_idx[i];
        assign ch_seq[i+1] = take ? s : ch_seq[i];
        assign ch_mem[i+1] = take ? is_mem[i] : ch_mem[i];
    end

    assign any = ch_any[NUM_PORTS];
    assign idx = ch_idx[NUM_PORTS];
endmodule

// File: rtl/sqr_msg_former.sv
// Message former: builds the next squash message from the winning event.
// A branch carries the full redirect with direction derived from the target;
// a memory event carries only sequence number and next PC.
module sqr_msg_former #(
    parameter int SEQ_W      = 16,
    parameter int PC_W       = 32,
    parameter int INST_BYTES = 4
) (
    input  logic             win_any,
    input  logic             win_is_mem,
    input  logic [SEQ_W-1:0] win_seq,
    input  logic [PC_W-1:0]  win_pc,
    input  logic [PC_W-1:0]  win_target,
    output logic [SEQ_W-1:0] nx_seq,
    output logic [PC_W-1:0]  nx_mispred_pc,
    output logic [PC_W-1:0]  nx_next_pc,
    output logic             nx_branch,
    output logic             nx_taken
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

    logic [PC_W-1:0] fall_through;
    logic            is_branch;

    // Fall-through address and cause decode
    assign fall_through = win_pc + STEP;
    assign is_branch    = win_any && !win_is_mem;

    // Field selection per cause; zero when no event
    always_comb begin
        nx_seq        = win_any ? win_seq : '0;
        nx_next_pc    = win_any ? win_target : '0;
        nx_branch     = is_branch;
        nx_mispred_pc = is_branch ? win_pc : '0;
        nx_taken      = is_branch && (win_target != fall_through);
    end
endmodule

// File: rtl/sqr_event_counter.sv
// Event counter: wrapping counter bumped by a one-cycle strobe.
module sqr_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    // Count strobes; synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (bump) count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/squash_redirect_gen.sv
// Squash redirect generator: arbitrates same-cycle squash events by age,
// registers one message per accepted event, tracks the squashing status
// and counts mispredicted predicted-taken branches and memory violations.
// Assumes event strobes last one cycle and that commit releases squashing.
module squash_redirect_gen #(
    parameter int NUM_PORTS  = 2,
    parameter int SEQ_W      = 16,
    parameter int PC_W       = 32,
    parameter int INST_BYTES = 4,
    parameter int CNT_W      = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS-1:0]       ev_valid,
    input  logic [NUM_PORTS-1:0]       ev_is_mem,
    input  logic [NUM_PORTS-1:0]       ev_pred_taken,
    input  logic [NUM_PORTS*SEQ_W-1:0] ev_seq,
    input  logic [NUM_PORTS*PC_W-1:0]  ev_pc,
    input  logic [NUM_PORTS*PC_W-1:0]  ev_target,
    input  logic                       squash_release,
    output logic                       sq_valid,
    output logic [SEQ_W-1:0]           sq_seq,
    output logic [PC_W-1:0]            sq_mispred_pc,
    output logic [PC_W-1:0]            sq_next_pc,
    output logic                       sq_branch_mispredict,
    output logic                       sq_taken,
    output logic                       squashing,
    output logic [CNT_W-1:0]           cnt_pred_taken_wrong,
    output logic [CNT_W-1:0]           cnt_mem_order
);
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic             win_any;
    logic [IDX_W-1:0] win_idx;
    logic             win_is_mem;
    logic             win_pred;
    logic [SEQ_W-1:0] win_seq;
    logic [PC_W-1:0]  win_pc;
    logic [PC_W-1:0]  win_target;

    logic [SEQ_W-1:0] nx_seq;
    logic [PC_W-1:0]  nx_mispred_pc;
    logic [PC_W-1:0]  nx_next_pc;
    logic             nx_branch;
    logic             nx_taken;

    logic             bump_pt;
    logic             bump_mem;

    sqr_age_arbiter #(
        .NUM_PORTS(NUM_PORTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W)
    ) u_arb (
        .req(ev_valid), .is_mem(ev_is_mem), .seq(ev_seq),
        .any(win_any), .idx(win_idx)
    );

    // Fetch the winning port's fields
    always_comb begin
        win_is_mem = ev_is_mem[win_idx];
        win_pred   = ev_pred_taken[win_idx];
        win_seq    = ev_seq[win_idx*SEQ_W +: SEQ_W];
        win_pc     = ev_pc[win_idx*PC_W +: PC_W];
        win_target = ev_target[win_idx*PC_W +: PC_W];
    end

    sqr_msg_former #(
        .SEQ_W(SEQ_W), .PC_W(PC_W), .INST_BYTES(INST_BYTES)
    ) u_form (
        .win_any(win_any), .win_is_mem(win_is_mem), .win_seq(win_seq),
        .win_pc(win_pc), .win_target(win_target),
        .nx_seq(nx_seq), .nx_mispred_pc(nx_mispred_pc), .nx_next_pc(nx_next_pc),
        .nx_branch(nx_branch), .nx_taken(nx_taken)
    );

    // Register the outgoing message for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_valid             <= 1'b0;
            sq_seq               <= '0;
            sq_mispred_pc        <= '0;
            sq_next_pc           <= '0;
            sq_branch_mispredict <= 1'b0;
            sq_taken             <= 1'b0;
        end else begin
            sq_valid             <= win_any;
            sq_seq               <= nx_seq;
            sq_mispred_pc        <= nx_mispred_pc;
            sq_next_pc           <= nx_next_pc;
            sq_branch_mispredict <= nx_branch;
            sq_taken             <= nx_taken;
        end
    end

    // Squashing status: set by any event, cleared by release when quiet
    always_ff @(posedge clk) begin
        if (!rst_n)              squashing <= 1'b0;
        else if (win_any)        squashing <= 1'b1;
        else if (squash_release) squashing <= 1'b0;
    end

    // Counter strobes for the winning event
    assign bump_pt  = win_any && !win_is_mem && win_pred;
    assign bump_mem = win_any && win_is_mem;

    sqr_event_counter #(.CNT_W(CNT_W)) u_cnt_pt (
        .clk(clk), .rst_n(rst_n), .bump(bump_pt), .count(cnt_pred_taken_wrong)
    );
    sqr_event_counter #(.CNT_W(CNT_W)) u_cnt_mem (
        .clk(clk), .rst_n(rst_n), .bump(bump_mem), .count(cnt_mem_order)
    );
endmodule

// File: rtl/sqr_checker.sv
// Checker for squash_redirect_gen: port-level temporal properties.
module sqr_checker #(
    parameter int NUM_PORTS = 2,
    parameter int SEQ_W     = 16,
    parameter int PC_W      = 32,
    parameter int CNT_W     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] ev_valid,
    input logic                 sq_valid,
    input logic [SEQ_W-1:0]     sq_seq,
    input logic [PC_W-1:0]      sq_mispred_pc,
    input logic [PC_W-1:0]      sq_next_pc,
    input logic                 sq_branch_mispredict,
    input logic                 sq_taken,
    input logic                 squashing,
    input logic [CNT_W-1:0]     cnt_pred_taken_wrong,
    input logic [CNT_W-1:0]     cnt_mem_order
);
    a_r2_msg_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> $past(|ev_valid));

    a_r5_mem_fields_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && !sq_branch_mispredict) |-> (sq_mispred_pc == '0 && !sq_taken));

    a_r8_squashing_with_msg: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> squashing);

    a_r9_pt_counter_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_pred_taken_wrong) |-> (sq_valid && sq_branch_mispredict));

    a_r10_mem_counter_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_mem_order) |-> (sq_valid && !sq_branch_mispredict));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_valid |-> (sq_seq == '0 && sq_mispred_pc == '0 && sq_next_pc == '0
                       && !sq_branch_mispredict && !sq_taken));
endmodule

bind squash_redirect_gen sqr_checker #(
    .NUM_PORTS(NUM_PORTS), .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)
) u_sqr_checker (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_mispred_pc(sq_mispred_pc),
    .sq_next_pc(sq_next_pc), .sq_branch_mispredict(sq_branch_mispredict),
    .sq_taken(sq_taken), .squashing(squashing),
    .cnt_pred_taken_wrong(cnt_pred_taken_wrong), .cnt_mem_order(cnt_mem_order)
);

// File: tb/squash_redirect_gen_test.sv
module squash_redirect_gen_test;
    localparam int NP = 2;
    localparam int SW = 4;
    localparam int PW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] ev_valid, ev_is_mem, ev_pred_taken;
    logic [NP*SW-1:0] ev_seq;
    logic [NP*PW-1:0] ev_pc, ev_target;
    logic          squash_release;
    logic          sq_valid, sq_branch_mispredict, sq_taken, squashing;
    logic [SW-1:0] sq_seq;
    logic [PW-1:0] sq_mispred_pc, sq_next_pc;
    logic [CW-1:0] cnt_pred_taken_wrong, cnt_mem_order;

    int checks = 0;
    int fails  = 0;
    int exp_pt = 0;
    int exp_mem = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    squash_redirect_gen #(.NUM_PORTS(NP), .SEQ_W(SW), .PC_W(PW), .INST_BYTES(4), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_is_mem(ev_is_mem),
        .ev_pred_taken(ev_pred_taken), .ev_seq(ev_seq), .ev_pc(ev_pc),
        .ev_target(ev_target), .squash_release(squash_release),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_mispred_pc(sq_mispred_pc),
        .sq_next_pc(sq_next_pc), .sq_branch_mispredict(sq_branch_mispredict),
        .sq_taken(sq_taken), .squashing(squashing),
        .cnt_pred_taken_wrong(cnt_pred_taken_wrong), .cnt_mem_order(cnt_mem_order)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs(input logic rel);
        ev_valid = '0; ev_is_mem = '0; ev_pred_taken = '0;
        ev_seq = '0; ev_pc = '0; ev_target = '0; squash_release = rel;
    endtask

    // Check message outputs against expected fields (one cycle after drive)
    task automatic chk_msg(input string req, input logic v, input logic [SW-1:0] s,
                           input logic [PW-1:0] mpc, input logic [PW-1:0] npc,
                           input logic br, input logic tk);
        chk(req, {sq_valid, sq_seq, sq_mispred_pc, sq_next_pc, sq_branch_mispredict, sq_taken},
                 {v, s, mpc, npc, br, tk});
    endtask

    initial begin
        rst_n = 1'b0;
        ev_valid = '1; ev_is_mem = '1; ev_pred_taken = '1;
        ev_seq = '1; ev_pc = '1; ev_target = '1; squash_release = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset clears outputs even with events presented
        chk("R1 reset outputs", {sq_valid, sq_seq, sq_mispred_pc, sq_next_pc, sq_branch_mispredict,
                                 sq_taken, squashing, cnt_pred_taken_wrong, cnt_mem_order}, '0);
        idle_inputs(1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", {sq_valid, sq_seq, sq_next_pc, squashing}, '0);

        // Exhaustive sweep over two ports
        for (int v = 1; v < 4; v++)
        for (int m = 0; m < 4; m++)
        for (int sa = 0; sa < 3; sa++)
        for (int sb = 0; sb < 3; sb++)
        for (int pr = 0; pr < 4; pr++)
        for (int tg = 0; tg < 4; tg++) begin
            logic [SW-1:0] sq [2];
            logic [PW-1:0] pc [2];
            logic [PW-1:0] tgt [2];
            int w;
            logic ebr, etk;
            sq[0] = SW'(2 + 3*sa);
            sq[1] = SW'(2 + 3*sb);
            for (int p = 0; p < 2; p++) begin
                pc[p]  = 32'h0000_1000 + 32'(p) * 32'h40 + 32'(sa*3 + sb) * 32'h400;
                tgt[p] = tg[p] ? pc[p] + 32'h100 : pc[p] + 32'd4;
            end
            ev_valid = 2'(v); ev_is_mem = 2'(m); ev_pred_taken = 2'(pr);
            ev_seq = {sq[1], sq[0]}; ev_pc = {pc[1], pc[0]}; ev_target = {tgt[1], tgt[0]};
            squash_release = 1'b0;
            // R6/R7: expected winner by age, branch on tie, then lower port
            if (v == 1) w = 0;
            else if (v == 2) w = 1;
            else if (sq[1] < sq[0]) w = 1;
            else if (sq[1] == sq[0] && !m[1] && m[0]) w = 1;
            else w = 0;
            ebr = !m[w];
            etk = ebr && (tgt[w] != pc[w] + 32'd4);
            if (ebr && pr[w]) exp_pt++;
            if (!ebr) exp_mem++;
            @(negedge clk);
            // R3/R4/R5/R6/R7: message content
            chk(ebr ? "R3 R4 R6 R7 branch msg" : "R5 R6 R7 mem msg", 
                {sq_valid, sq_seq, sq_mispred_pc, sq_next_pc, sq_branch_mispredict, sq_taken},
                {1'b1, sq[w], ebr ? pc[w] : 32'h0, tgt[w], ebr, etk});
            chk("R9 pred-taken counter", cnt_pred_taken_wrong, CW'(exp_pt));
            chk("R10 mem counter", cnt_mem_order, CW'(exp_mem));
            chk("R8 squashing set", squashing, 1'b1);
            idle_inputs(1'b1);
            @(negedge clk);
            // R2: one-cycle pulse; R11 zero fields; R8 release clears
            chk_msg("R2 R11 pulse ends", 1'b0, '0, '0, '0, 1'b0, 1'b0);
            chk("R8 released", squashing, 1'b0);
        end

        // R8: status held without release, kept when event meets release
        ev_valid = 2'b01; ev_is_mem = 2'b01; ev_seq = {4'd0, 4'd7};
        ev_target = {32'd0, 32'h2000}; squash_release = 1'b0;
        exp_mem++;
        @(negedge clk);
        idle_inputs(1'b0);
        repeat (3) @(negedge clk);
        chk("R8 held without release", squashing, 1'b1);
        chk("R2 no repeat message", sq_valid, 1'b0);
        ev_valid = 2'b10; ev_is_mem = 2'b00; ev_pred_taken = 2'b10; ev_seq = {4'd3, 4'd0};
        ev_pc = {32'h3000, 32'd0}; ev_target = {32'h3004, 32'd0}; squash_release = 1'b1;
        exp_pt++;
        @(negedge clk);
        // R4: predicted taken but target is fall-through -> taken 0
        chk_msg("R4 fall-through not taken", 1'b1, 4'd3, 32'h3000, 32'h3004, 1'b1, 1'b0);
        chk("R8 event beats release", squashing, 1'b1);
        chk("R9 counter", cnt_pred_taken_wrong, CW'(exp_pt));
        chk("R10 counter", cnt_mem_order, CW'(exp_mem));
        idle_inputs(1'b1);
        @(negedge clk);
        chk("R8 release clears", squashing, 1'b0);

        // R1: reset mid-run clears counters
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset counters", {cnt_pred_taken_wrong, cnt_mem_order, squashing}, '0);
        done = 1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done == 1);
            begin
                repeat (150000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule